// File: doc/BRIEF.md
# Fault Flag and Interrupt Pulser

This block gathers fault and event indications from a power-management controller. Each source has two bits. A live status bit shows the input as it was on the previous clock. A sticky flag bit records that the source fired. Whenever a flag goes from clear to set, the block pulls an active-low interrupt line low for a fixed number of timing ticks. A host that sees the pulse reads the flag registers through a read strobe and a register index.

Each source is one of two kinds, chosen by a parameter mask. A condition source, such as input over-voltage, keeps its flag as long as the condition lasts. A host read clears that flag only once the condition has gone away. An event source, such as an expired charge timer, sets its flag when its input rises. Any read of its register clears that flag, even while the input is still high.

Only one pulse runs at a time. Flags that become set while a pulse is running or in its trailing gap queue exactly one more pulse. That pulse starts after the line has been high until the next tick.

Top module: `fault_irq_pulser`

## Requirements
- R1: `status[i]` equals the value `src_in[i]` had at the previous rising clock edge, for every source.
- R2: A condition source (bit clear in `EVENT_MASK`) sets its flag in every cycle its input is high. A read of its register during such a cycle leaves the flag set. After the input has gone low the flag stays set until a read of its register clears it.
- R3: An event source (bit set in `EVENT_MASK`; default `8'hCC`, so sources 2, 3, 6 and 7) sets its flag only when its input rises between two clock edges. Any read of its register clears the flag even while the input is still high, and holding the input high does not set the flag again.
- R4: A read strobe with `rd_idx` = k acts only on sources k*REG_W to k*REG_W+REG_W-1. With the defaults, index 0 holds sources 0 to 3 and index 1 holds sources 4 to 7.
- R5: The clock edge at which a flag goes from clear to set, with no pulse running, also drives `irq_n` low. `irq_n` stays low until exactly `PULSE_TICKS` tick strobes (default 128) have been sampled while it is low.
- R6: A pulse is started only by a flag going from clear to set. Flags that rise together give one pulse. A flag that stays set, or an event input that toggles while its flag is still set, starts no further pulse.
- R7: A flag that becomes set while a pulse is running or in its gap queues one more pulse, and any number of such flags merge into that one. The running pulse is not lengthened. The queued pulse starts only after `irq_n` has been high across at least one tick.
- R8: A flag being set and a read of its register in the same cycle leave the flag set.
- R9: The pulse length is counted in ticks, not in clock cycles. With a tick every D cycles, `irq_n` stays low for between (PULSE_TICKS-1)*D+1 and PULSE_TICKS*D cycles.
- R10: Once a flag has been cleared by a read, the next set of that flag starts a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing strobe that paces the pulse length |
| src_in | input | N_SRC | Fault and event inputs, one per source |
| rd_stb | input | 1 | Host read strobe for one flag register |
| rd_idx | input | IDX_W | Index of the flag register being read |
| status | output | N_SRC | Live status, registered |
| flags | output | N_SRC | Sticky flags |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
The bound checker watches four things on every clock edge. It checks that status tracks its inputs. It checks that no condition flag is ever low in the cycle after its input was high. It checks that every low stretch of the interrupt lasts exactly the programmed number of ticks and never runs past that number.

Other behaviours need a stimulus history, so only the bench scenarios can show them:
- how many pulses a burst of new flags produces, and the merging of late flags into a single queued pulse;
- clear-on-read for events while the input is still high;
- read isolation between registers;
- set-over-read priority;
- re-arming after a clear.

// File: rtl/fault_irq_pulser.sv
module fault_irq_pulser #(
  parameter int N_SRC = 8,
  parameter int REG_W = 4,
  parameter logic [N_SRC-1:0] EVENT_MASK = 8'hCC,
  parameter int PULSE_TICKS = 128,
  localparam int N_REG = (N_SRC + REG_W - 1) / REG_W,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int CNT_W = $clog2(PULSE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [N_SRC-1:0] src_in,
  input  logic             rd_stb,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [N_SRC-1:0] status,
  output logic [N_SRC-1:0] flags,
  output logic             irq_n
);

  typedef enum logic [1:0] {PS_IDLE, PS_LOW, PS_GAP} pstate_t;

  logic [N_SRC-1:0] status_q, flag_q, set_v, rd_hit;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, req;
  pstate_t          st_q;

  always_comb begin
    for (int i = 0; i < N_SRC; i++)
      rd_hit[i] = rd_stb && (rd_idx == IDX_W'(i / REG_W));
  end

  assign set_v = (src_in & ~EVENT_MASK) | (src_in & ~status_q & EVENT_MASK);
  assign req   = |(set_v & ~flag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      flag_q   <= '0;
    end else begin
      status_q <= src_in;
      flag_q   <= (flag_q & ~rd_hit) | set_v;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      case (st_q)
        PS_IDLE: if (req) begin
          st_q  <= PS_LOW;
          cnt_q <= '0;
        end
        PS_LOW: begin
          if (req) pend_q <= 1'b1;
          if (tick) begin
            if (cnt_q == CNT_W'(PULSE_TICKS - 1)) st_q <= PS_GAP;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        PS_GAP: begin
          if (tick) begin
            if (pend_q || req) begin
              st_q   <= PS_LOW;
              cnt_q  <= '0;
              pend_q <= 1'b0;
            end else begin
              st_q <= PS_IDLE;
            end
          end else if (req) begin
            pend_q <= 1'b1;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  assign status = status_q;
  assign flags  = flag_q;
  assign irq_n  = (st_q != PS_LOW);

endmodule

// File: rtl/fault_irq_pulser_chk.sv
module fault_irq_pulser_chk #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] EVENT_MASK = 8'hCC,
  parameter int PULSE_TICKS = 128,
  localparam int CW = $clog2(PULSE_TICKS + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [N_SRC-1:0] src_in,
  input logic [N_SRC-1:0] status,
  input logic [N_SRC-1:0] flags,
  input logic             irq_n
);

  logic          past_ok;
  logic [CW-1:0] low_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok   <= 1'b0;
      low_ticks <= '0;
    end else begin
      past_ok <= 1'b1;
      if (irq_n) low_ticks <= '0;
      else if (tick) low_ticks <= low_ticks + 1'b1;
    end
  end

  // R1
  status_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> status == $past(src_in));

  // R2
  cond_flag_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(src_in) & ~EVENT_MASK & ~flags) == '0));

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> low_ticks == CW'(PULSE_TICKS));

  // R5
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_ticks <= CW'(PULSE_TICKS));

endmodule

bind fault_irq_pulser fault_irq_pulser_chk #(
  .N_SRC(N_SRC), .EVENT_MASK(EVENT_MASK), .PULSE_TICKS(PULSE_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .src_in(src_in),
  .status(status), .flags(flags), .irq_n(irq_n)
);

// File: tb/tb_fault_irq_pulser.sv
module tb_fault_irq_pulser;
  localparam int P = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [7:0] src = '0;
  logic       rd_stb = 1'b0;
  logic [0:0] rd_idx = '0;
  logic [7:0] status, flags;
  logic       irq_n;

  int n_chk = 0, n_err = 0, n_pulse = 0;
  int tick_div = 1, div_cnt = 0;
  int low_cnt = 0, gap_cnt = 0, low_cyc = 0, last_low_cyc = 0;
  logic prev_irq = 1'b1;
  bit done = 0;
  string exp_q[$];

  fault_irq_pulser dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .src_in(src),
    .rd_stb(rd_stb), .rd_idx(rd_idx),
    .status(status), .flags(flags), .irq_n(irq_n)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tick <= (div_cnt == 0);
    div_cnt <= (div_cnt + 1 >= tick_div) ? 0 : div_cnt + 1;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_pulse(string tag);
    exp_q.push_back(tag);
  endtask

  // monitor: measures each low pulse in ticks and compares with the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_irq && tick) low_cnt++;
      if (prev_irq && tick) gap_cnt++;
      if (!prev_irq) low_cyc++;
      if (prev_irq && !irq_n) begin
        check(gap_cnt >= 1, "R7 gap", gap_cnt, 1);
        gap_cnt = 0;
        low_cnt = 0;
        low_cyc = 0;
      end
      if (!prev_irq && irq_n) begin
        n_pulse++;
        last_low_cyc = low_cyc;
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected pulse", 1, 0);
        end else begin
          string tg;
          tg = exp_q.pop_front();
          check(low_cnt == P, tg, low_cnt, P);
        end
        low_cnt = 0;
      end
      prev_irq = irq_n;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(int idx);
    @(negedge clk);
    rd_stb = 1'b1;
    rd_idx = 1'(idx);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic drain();
    int w = 0;
    while (exp_q.size() != 0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    step(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int np;
    step(4);
    rst_n = 1'b1;
    step(2);
    check(status == 0, "R1 reset", status, 0);
    check(flags == 0, "R2 reset", flags, 0);
    check(irq_n == 1, "R5 reset", irq_n, 1);

    // condition source 0
    src[0] = 1'b1;
    expect_pulse("R5");
    @(negedge clk);
    check(status[0] == 1, "R1", status, 8'h01);
    check(flags == 8'h01, "R2", flags, 8'h01);
    check(irq_n == 0, "R5 start", irq_n, 0);
    step(20);
    do_read(0);
    check(flags[0] == 1, "R2 read while high", flags, 8'h01);
    step(200);
    src[0] = 1'b0;
    @(negedge clk);
    check(status[0] == 0, "R1 fall", status, 0);
    check(flags[0] == 1, "R2 held", flags, 8'h01);
    do_read(0);
    check(flags == 0, "R2 cleared", flags, 0);
    drain();
    check(n_pulse == 1, "R6 single pulse", n_pulse, 1);

    // event source 2
    src[2] = 1'b1;
    expect_pulse("R3");
    @(negedge clk);
    check(flags == 8'h04, "R3 set", flags, 8'h04);
    step(5);
    do_read(0);
    check(flags == 0, "R3 clear while high", flags, 0);
    check(status[2] == 1, "R3 still high", status, 8'h04);
    step(200);
    check(flags == 0, "R3 no reset", flags, 0);
    src[2] = 1'b0;
    drain();

    // group isolation
    src[6] = 1'b1;
    src[1] = 1'b1;
    expect_pulse("R6");
    @(negedge clk);
    check(flags == 8'h42, "R4 both set", flags, 8'h42);
    src[6] = 1'b0;
    src[1] = 1'b0;
    @(negedge clk);
    do_read(1);
    check(flags == 8'h02, "R4 read idx1", flags, 8'h02);
    do_read(0);
    check(flags == 0, "R4 read idx0", flags, 0);
    drain();
    check(n_pulse == 3, "R6 merged start", n_pulse, 3);

    // queued pulse
    np = n_pulse;
    src[0] = 1'b1;
    expect_pulse("R7");
    step(10);
    src[4] = 1'b1;
    expect_pulse("R7");
    step(10);
    src[7] = 1'b1;
    step(3);
    src = '0;
    drain();
    check(n_pulse == np + 2, "R7 one queued", n_pulse - np, 2);
    check(flags == 8'h91, "R7 flags", flags, 8'h91);
    do_read(0);
    do_read(1);
    check(flags == 0, "R7 cleared", flags, 0);

    // set and read in one cycle
    @(negedge clk);
    src[3] = 1'b1;
    rd_stb = 1'b1;
    rd_idx = 1'b0;
    expect_pulse("R8");
    @(negedge clk);
    rd_stb = 1'b0;
    check(flags[3] == 1, "R8 set wins", flags, 8'h08);
    src[3] = 1'b0;
    drain();
    do_read(0);
    check(flags == 0, "R8 cleared", flags, 0);

    // toggle event while flag set, then re-arm
    np = n_pulse;
    src[2] = 1'b1;
    expect_pulse("R6");
    step(3);
    src[2] = 1'b0;
    step(3);
    src[2] = 1'b1;
    step(3);
    src[2] = 1'b0;
    drain();
    check(n_pulse == np + 1, "R6 toggle no pulse", n_pulse - np, 1);
    do_read(0);
    src[2] = 1'b1;
    expect_pulse("R10");
    step(2);
    src[2] = 1'b0;
    drain();
    check(n_pulse == np + 2, "R10 rearm", n_pulse - np, 2);
    do_read(0);

    // sparse tick
    tick_div = 3;
    step(5);
    src[5] = 1'b1;
    expect_pulse("R9");
    step(2);
    src[5] = 1'b0;
    drain();
    check(last_low_cyc >= 3 * (P - 1) + 1 && last_low_cyc <= 3 * P,
          "R9 cycles", last_low_cyc, 3 * P);
    check(flags == 8'h20, "R2 cond held", flags, 8'h20);
    do_read(1);
    check(flags == 0, "R4 cleared", flags, 0);
    tick_div = 1;
    step(5);

    check(exp_q.size() == 0, "R5 missing pulses", exp_q.size(), 0);
    finish_run();
  end
endmodule